// File: doc/BRIEF.md
# Queued Command Front End for a Bus-Attached Arithmetic Coprocessor

This block sits between a small 8-bit host processor and an arithmetic unit that does the real number crunching. It occupies a 256-byte window on the host bus. Every host write in that window is one 16-bit command: the eight address bits and the eight data bits form the command together. The command names an operation, a destination register and two source registers. Commands go into an in-order queue, so the host can post several of them and carry on with other work while they drain.

The block holds a 16-entry register file. Loading a register, selecting a register for readback and doing arithmetic are all operation codes in the same 4-bit command space. A load shifts one data byte into the destination register, least significant byte first. A readback returns one byte of the selected register per host read. Arithmetic commands go to the external unit over a valid/ready handshake that carries the operation and both operand values. The unit's result comes back on a result-valid strobe and is written to the destination register. Arithmetic itself is outside this block.

Top module: `fpfe_top`

## Requirements
- R1: A host write with `bus_wr` high forms the command {bus_addr, bus_wdata}. Bits 15:12 are the opcode (`bus_addr[7:4]`), bits 11:8 the destination index (`bus_addr[3:0]`), bits 7:4 source A (`bus_wdata[7:4]`) and bits 3:0 source B (`bus_wdata[3:0]`).
- R2: Opcode 0x1 (load) shifts the register right by one byte and places the low command byte (source A, source B) in its top byte. After DATA_W/8 loads, the first byte written sits in bits 7:0.
- R3: Opcode 0x2 (select) picks the destination register for readback and clears the byte pointer. Each host read at an address other than 0xFF returns byte `ptr` of that register (bits 8*ptr+7 : 8*ptr) and then advances the pointer. The pointer wraps to byte 0 after byte DATA_W/8-1.
- R4: Opcodes 0x8 to 0xF are issued with `iss_valid` high. `iss_op` carries the opcode, and `iss_a`/`iss_b` carry the current contents of source A/B. All of these are held steady until `iss_ready` is seen high.
- R5: After issue, the next `res_valid` writes `res_data` to the command's destination register. A `res_valid` while no operation is outstanding is ignored.
- R6: Commands take effect strictly in the order written. No queued command takes effect until the result of an earlier arithmetic command has been written.
- R7: The queue holds 8 commands. Status bit 1 (full) is high while 8 commands are pending.
- R8: A write made while the queue is full is dropped and sets status bit 2 (overflow). That bit stays set until reset.
- R9: A host read at address 0xFF returns the status byte: bit 0 busy (queue not empty or an operation outstanding), bit 1 full, bit 2 overflow, other bits 0. A status read changes neither the queue nor the readback pointer.
- R10: Opcodes 0x0 and 0x3 to 0x7 are removed from the queue with no effect on any register or on the issue interface.
- R11: A synchronous reset empties the queue, clears the flags, zeroes all 16 registers, and sets readback to register 0, byte 0.
- R12: A host write and a queue removal in the same cycle are both honoured. Writes on every cycle while the queue drains lose no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 8 | Host address within the 256-byte window |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Host write strobe, one command per cycle |
| bus_rd | input | 1 | Host read strobe |
| bus_rdata | output | 8 | Host read data: status at 0xFF, readback byte elsewhere |
| iss_valid | output | 1 | Arithmetic command offered to the unit |
| iss_ready | input | 1 | Unit accepts the offered command |
| iss_op | output | 4 | Opcode of the offered command |
| iss_a | output | DATA_W | Source A operand |
| iss_b | output | DATA_W | Source B operand |
| res_valid | input | 1 | Unit returns a result |
| res_data | input | DATA_W | Result value |

## Verification
A host write into the queue and the sequencer taking the head entry can happen in the same clock. This is provoked by writing a load command on every cycle of a burst into an empty queue, so each new entry arrives just as the previous one leaves. The register is then read back and must hold the last four bytes of the burst, and the overflow flag must still be clear. The opposite corner holds the unit's ready low so the queue fills. There, the dropped ninth write and the post-release register contents show that the write was lost and that order was kept behind the stalled operation.

// File: rtl/fpfe_pkg.sv
package fpfe_pkg;

    localparam int IDX_W = 4;
    localparam int OP_W  = 4;

    localparam logic [OP_W-1:0] OP_LOAD = 4'h1;
    localparam logic [OP_W-1:0] OP_SEL  = 4'h2;

    // command word: address byte above, data byte below
    typedef struct packed {
        logic [OP_W-1:0]  op;
        logic [IDX_W-1:0] dst;
        logic [IDX_W-1:0] sa;
        logic [IDX_W-1:0] sb;
    } cmd_t;

    typedef enum logic [1:0] {
        DS_IDLE  = 2'd0,
        DS_ISSUE = 2'd1,
        DS_WAIT  = 2'd2
    } dstate_e;

endpackage

// File: rtl/fpfe_cmd_queue.sv
module fpfe_cmd_queue
    import fpfe_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  logic pop,
    input  cmd_t wr_cmd,
    output cmd_t head,
    output logic empty,
    output logic full
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        cmd_t [DEPTH-1:0] slot;
        logic [PW-1:0]    wp;
        logic [PW-1:0]    rp;
        logic [CW-1:0]    cnt;
    } q_t;

    q_t   s_d, s_q;
    logic accept;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        if (p == PW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == CW'(DEPTH));
    assign head  = s_q.slot[s_q.rp];

    always_comb begin
        s_d    = s_q;
        accept = push && !full;
        if (accept) begin
            s_d.slot[s_q.wp] = wr_cmd;
            s_d.wp           = bump(s_q.wp);
        end
        if (pop) begin
            s_d.rp = bump(s_q.rp);
        end
        case ({accept, pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        s_q.cnt <= CW'(DEPTH));

    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    p_drop_when_full_r8: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (full && $stable(s_q.wp)));

endmodule

// File: rtl/fpfe_regfile.sv
module fpfe_regfile
    import fpfe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [IDX_W-1:0]  ld_idx,
    input  logic [7:0]        ld_byte,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic [IDX_W-1:0]  rc_idx,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data,
    output logic [DATA_W-1:0] rc_data
);

    localparam int NREG = 1 << IDX_W;

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] r;
    } rf_t;

    rf_t               s_d, s_q;
    logic [DATA_W-1:0] nxt [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_comb begin
                nxt[g] = s_q.r[g];
                if (wb_en && wb_idx == IDX_W'(g)) begin
                    nxt[g] = wb_data;
                end else if (ld_en && ld_idx == IDX_W'(g)) begin
                    nxt[g] = {ld_byte, s_q.r[g][DATA_W-1:8]};
                end
            end
        end
    endgenerate

    always_comb begin
        for (int i = 0; i < NREG; i++) begin
            s_d.r[i] = nxt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ra_data = s_q.r[ra_idx];
    assign rb_data = s_q.r[rb_idx];
    assign rc_data = s_q.r[rc_idx];

    p_port_excl_r5: assert property (@(posedge clk) disable iff (rst)
        !(ld_en && wb_en));

    p_load_shift_r2: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !wb_en) |=>
        (s_q.r[$past(ld_idx)][DATA_W-1:DATA_W-8] == $past(ld_byte)));

endmodule

// File: rtl/fpfe_dispatch.sv
module fpfe_dispatch
    import fpfe_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              q_empty,
    input  cmd_t              q_head,
    output logic              q_pop,
    output logic [IDX_W-1:0]  opa_idx,
    output logic [IDX_W-1:0]  opb_idx,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              ld_en,
    output logic [IDX_W-1:0]  ld_idx,
    output logic [7:0]        ld_byte,
    output logic              sel_en,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              wb_en,
    output logic [IDX_W-1:0]  wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_op,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data,
    output logic              inflight
);

    typedef struct packed {
        dstate_e st;
        cmd_t    cur;
    } ds_t;

    ds_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        q_pop  = 1'b0;
        ld_en  = 1'b0;
        sel_en = 1'b0;
        wb_en  = 1'b0;
        case (s_q.st)
            DS_IDLE: begin
                if (!q_empty) begin
                    q_pop = 1'b1;
                    if (q_head.op == OP_LOAD) begin
                        ld_en = 1'b1;
                    end else if (q_head.op == OP_SEL) begin
                        sel_en = 1'b1;
                    end else if (q_head.op[OP_W-1]) begin
                        s_d.cur = q_head;
                        s_d.st  = DS_ISSUE;
                    end
                end
            end
            DS_ISSUE: begin
                if (iss_ready) s_d.st = DS_WAIT;
            end
            DS_WAIT: begin
                if (res_valid) begin
                    wb_en  = 1'b1;
                    s_d.st = DS_IDLE;
                end
            end
            default: s_d.st = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ld_idx    = q_head.dst;
    assign ld_byte   = {q_head.sa, q_head.sb};
    assign sel_idx   = q_head.dst;
    assign wb_idx    = s_q.cur.dst;
    assign wb_data   = res_data;
    assign opa_idx   = s_q.cur.sa;
    assign opb_idx   = s_q.cur.sb;
    assign iss_valid = (s_q.st == DS_ISSUE);
    assign iss_op    = s_q.cur.op;
    assign iss_a     = opa;
    assign iss_b     = opb;
    assign inflight  = (s_q.st != DS_IDLE);

    p_issue_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_ready) |=>
        (iss_valid && $stable(iss_op) && $stable(iss_a) && $stable(iss_b)));

    p_no_pop_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid || (inflight && !res_valid)) |=> !$past(q_pop));

endmodule

// File: rtl/fpfe_top.sv
module fpfe_top
    import fpfe_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          QDEPTH    = 8,
    parameter logic [7:0]  STAT_ADDR = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [OP_W-1:0]   iss_op,
    output logic [DATA_W-1:0] iss_a,
    output logic [DATA_W-1:0] iss_b,
    input  logic              res_valid,
    input  logic [DATA_W-1:0] res_data
);

    localparam int NB   = DATA_W / 8;
    localparam int PTRW = (NB > 1) ? $clog2(NB) : 1;

    typedef struct packed {
        logic             ovf;
        logic [IDX_W-1:0] sel;
        logic [PTRW-1:0]  ptr;
    } fe_t;

    fe_t  s_d, s_q;

    cmd_t              cmd_in, q_head;
    logic              q_empty, q_full, q_pop;
    logic [IDX_W-1:0]  opa_idx, opb_idx, ld_idx, sel_idx, wb_idx;
    logic [DATA_W-1:0] opa, opb, rc_data, wb_data, rb_shift;
    logic              ld_en, sel_en, wb_en, inflight, busy, data_rd;
    logic [7:0]        ld_byte;

    assign cmd_in = cmd_t'({bus_addr, bus_wdata});

    fpfe_cmd_queue #(.DEPTH(QDEPTH)) u_queue (
        .clk    (clk),
        .rst    (rst),
        .push   (bus_wr),
        .pop    (q_pop),
        .wr_cmd (cmd_in),
        .head   (q_head),
        .empty  (q_empty),
        .full   (q_full)
    );

    fpfe_dispatch #(.DATA_W(DATA_W)) u_disp (
        .clk       (clk),
        .rst       (rst),
        .q_empty   (q_empty),
        .q_head    (q_head),
        .q_pop     (q_pop),
        .opa_idx   (opa_idx),
        .opb_idx   (opb_idx),
        .opa       (opa),
        .opb       (opb),
        .ld_en     (ld_en),
        .ld_idx    (ld_idx),
        .ld_byte   (ld_byte),
        .sel_en    (sel_en),
        .sel_idx   (sel_idx),
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .wb_data   (wb_data),
        .iss_valid (iss_valid),
        .iss_ready (iss_ready),
        .iss_op    (iss_op),
        .iss_a     (iss_a),
        .iss_b     (iss_b),
        .res_valid (res_valid),
        .res_data  (res_data),
        .inflight  (inflight)
    );

    fpfe_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .ld_en   (ld_en),
        .ld_idx  (ld_idx),
        .ld_byte (ld_byte),
        .wb_en   (wb_en),
        .wb_idx  (wb_idx),
        .wb_data (wb_data),
        .ra_idx  (opa_idx),
        .rb_idx  (opb_idx),
        .rc_idx  (s_q.sel),
        .ra_data (opa),
        .rb_data (opb),
        .rc_data (rc_data)
    );

    assign busy     = !q_empty || inflight;
    assign data_rd  = bus_rd && (bus_addr != STAT_ADDR);
    assign rb_shift = rc_data >> (8 * s_q.ptr);

    always_comb begin
        s_d = s_q;
        if (bus_wr && q_full) s_d.ovf = 1'b1;
        if (sel_en) begin
            s_d.sel = sel_idx;
            s_d.ptr = '0;
        end else if (data_rd) begin
            if (s_q.ptr == PTRW'(NB - 1)) s_d.ptr = '0;
            else                          s_d.ptr = s_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    always_comb begin
        if (bus_addr == STAT_ADDR) bus_rdata = {5'b0, s_q.ovf, q_full, busy};
        else                       bus_rdata = rb_shift[7:0];
    end

    p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        s_q.ovf |=> s_q.ovf);

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && q_full) |=> s_q.ovf);

    p_stat_rd_ptr_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == STAT_ADDR && !sel_en) |=> $stable(s_q.ptr));

    p_sel_clears_ptr_r3: assert property (@(posedge clk) disable iff (rst)
        sel_en |=> (s_q.ptr == '0));

    p_busy_issue_r9: assert property (@(posedge clk) disable iff (rst)
        iss_valid |-> bus_addr != STAT_ADDR || bus_rdata[0]);

endmodule

// File: tb/sim_fpfe_top.sv
module sim_fpfe_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = '0, bus_wdata = '0;
    logic         bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]   bus_rdata;
    logic         iss_valid, iss_ready, res_valid;
    logic [3:0]   iss_op;
    logic [W-1:0] iss_a, iss_b, res_data;

    logic         stall = 1'b0, m_valid = 1'b0, poke_valid = 1'b0;
    logic [W-1:0] m_data = '0, poke_data = '0, m_a = '0, m_b = '0;
    logic [3:0]   m_op = '0;
    int           n_issue = 0, n_cmp = 0, n_bad = 0;

    assign iss_ready = !stall;
    assign res_valid = m_valid | poke_valid;
    assign res_data  = poke_valid ? poke_data : m_data;

    always #2.5 clk = ~clk;

    fpfe_top u0 (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .iss_valid (iss_valid),
        .iss_ready (iss_ready),
        .iss_op    (iss_op),
        .iss_a     (iss_a),
        .iss_b     (iss_b),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    typedef struct packed {
        logic [3:0]   op;
        logic [3:0]   dst;
        logic [3:0]   sa;
        logic [3:0]   sb;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W-1:0] exp;
    } vec_t;

    // unit model: 8 add, 9 subtract, others exclusive-or
    localparam vec_t VECS [0:4] = '{
        '{4'h8, 4'h3, 4'h1, 4'h2, 32'h00000010, 32'h00000020, 32'h00000030},
        '{4'h9, 4'h4, 4'h5, 4'h6, 32'h12345678, 32'h00000078, 32'h12345600},
        '{4'hA, 4'h7, 4'h7, 4'h8, 32'hFF00FF00, 32'h0F0F0F0F, 32'hF00FF00F},
        '{4'h8, 4'h0, 4'h9, 4'h9, 32'h40000001, 32'h40000001, 32'h80000002},
        '{4'hF, 4'hF, 4'hE, 4'hD, 32'h11111111, 32'h22222222, 32'h33333333}
    };

    initial begin
        forever begin
            @(negedge clk);
            if (iss_valid && !stall) begin
                m_op = iss_op;
                m_a  = iss_a;
                m_b  = iss_b;
                n_issue++;
                repeat (3) @(negedge clk);
                if (m_op == 4'h8)      m_data = m_a + m_b;
                else if (m_op == 4'h9) m_data = m_a - m_b;
                else                   m_data = m_a ^ m_b;
                m_valid = 1'b1;
                @(negedge clk);
                m_valid = 1'b0;
            end
        end
    end

    task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd   = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        int k;
        s = 8'h01;
        k = 0;
        while (s[0] && k < 1000) begin
            host_rd(8'hFF, s);
            k++;
        end
        if (s[0]) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R9 busy never cleared: got %h expected 00", s);
        end
    endtask

    task automatic load_reg(input logic [3:0] idx, input logic [W-1:0] v);
        for (int i = 0; i < W / 8; i++) host_wr({4'h1, idx}, v[8*i +: 8]);
    endtask

    task automatic read_reg(input logic [3:0] idx, output logic [W-1:0] v);
        logic [7:0] b;
        host_wr({4'h2, idx}, 8'h00);
        wait_idle();
        v = '0;
        for (int i = 0; i < W / 8; i++) begin
            host_rd(8'h00, b);
            v[8*i +: 8] = b;
        end
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: got hang expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [7:0]   s, b;
        logic [W-1:0] v;
        int           iss0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R11: reset state
        host_rd(8'hFF, s);
        check("R11 status after reset", W'(s), '0);
        read_reg(4'h0, v);
        check("R11 reg0 after reset", v, '0);
        read_reg(4'hF, v);
        check("R11 reg15 after reset", v, '0);

        // R1 R2 R4 R5: vector table
        for (int i = 0; i < 5; i++) begin
            load_reg(VECS[i].sa, VECS[i].a);
            load_reg(VECS[i].sb, VECS[i].b);
            host_wr({VECS[i].op, VECS[i].dst}, {VECS[i].sa, VECS[i].sb});
            wait_idle();
            check("R1 R4 issued opcode", W'(m_op), W'(VECS[i].op));
            check("R4 operand A", m_a, VECS[i].a);
            check("R4 operand B", m_b, VECS[i].b);
            read_reg(VECS[i].dst, v);
            check("R5 result in destination", v, VECS[i].exp);
        end

        // R5: stray result strobe while idle
        @(negedge clk);
        poke_data  = 32'hDEADBEEF;
        poke_valid = 1'b1;
        @(negedge clk);
        poke_valid = 1'b0;
        read_reg(4'hF, v);
        check("R5 stray result ignored", v, 32'h33333333);

        // R2 R3: byte order and pointer wrap
        load_reg(4'hC, 32'hA1B2C3D4);
        host_wr(8'h2C, 8'h00);
        wait_idle();
        host_rd(8'h00, b); check("R3 byte0", W'(b), 32'hD4);
        host_rd(8'h00, b); check("R3 byte1", W'(b), 32'hC3);
        host_rd(8'h00, b); check("R3 byte2", W'(b), 32'hB2);
        host_rd(8'h00, b); check("R3 byte3", W'(b), 32'hA1);
        host_rd(8'h00, b); check("R3 pointer wrap", W'(b), 32'hD4);

        // R9: status read leaves pointer alone
        host_wr(8'h2C, 8'h00);
        wait_idle();
        host_rd(8'h00, b); check("R9 first byte", W'(b), 32'hD4);
        host_rd(8'hFF, s); check("R9 idle status", W'(s), '0);
        host_rd(8'h00, b); check("R9 pointer unmoved by status", W'(b), 32'hC3);

        // R10: inert opcodes
        iss0 = n_issue;
        load_reg(4'hB, 32'h55667788);
        host_wr(8'h0B, 8'hBB);
        host_wr(8'h5B, 8'hBB);
        host_wr(8'h3B, 8'h12);
        wait_idle();
        check("R10 nothing issued", W'(n_issue), W'(iss0));
        read_reg(4'hB, v);
        check("R10 register untouched", v, 32'h55667788);

        // R12: write and dequeue in the same cycle
        @(negedge clk);
        bus_wr = 1'b1;
        for (int i = 0; i < 6; i++) begin
            bus_addr  = 8'h16;
            bus_wdata = 8'(8'h11 * (i + 1));
            @(negedge clk);
        end
        bus_wr = 1'b0;
        wait_idle();
        read_reg(4'h6, v);
        check("R12 burst kept every byte", v, 32'h66554433);
        host_rd(8'hFF, s);
        check("R12 no overflow on burst", W'(s), '0);

        // R6 R7 R8: fill behind a stalled operation
        @(posedge clk);
        #1 stall = 1'b1;
        host_wr(8'h8A, 8'h12);
        repeat (2) @(negedge clk);
        host_wr(8'h1A, 8'h01);
        host_wr(8'h1A, 8'h02);
        for (int i = 0; i < 6; i++) host_wr(8'h1D, 8'(8'h31 + i));
        host_rd(8'hFF, s);
        check("R7 full and busy", W'(s), 32'h03);
        host_wr(8'h1A, 8'h09);
        host_rd(8'hFF, s);
        check("R8 overflow set", W'(s), 32'h07);
        @(posedge clk);
        #1 stall = 1'b0;
        wait_idle();
        read_reg(4'hA, v);
        check("R6 R8 order kept, extra write dropped", v, 32'h02010000);
        read_reg(4'hD, v);
        check("R6 later loads applied", v, 32'h36353433);
        host_rd(8'hFF, s);
        check("R8 overflow sticky", W'(s), 32'h04);

        // R11: reset clears flags and registers
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        host_rd(8'hFF, s);
        check("R11 flags cleared", W'(s), '0);
        read_reg(4'hA, v);
        check("R11 registers cleared", v, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule